// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a client and a serial-flash command engine. It takes two kinds of request. A write request carries a start address, a length and a byte stream. An erase request carries the address of a sector. The block then drives the engine through the full command sequence with no further help from the client.

For every unit of work, the block first sends a write-enable command. It then sends the program or sector-erase command. After that it reads the flash status byte again and again until the busy bit is low. Writes are cut into pieces of at most four bytes. A piece never runs past the end of a 256-byte page, because the flash would otherwise wrap the extra bytes back to the start of the same page.

A request that does not fit inside the flash is refused with an error, and no command is sent for it. A write of length zero finishes at once. When the whole request is finished, one pulse on the response port reports it, with or without an error.

Top module: `flash_pe_seq`

## Requirements
- R1: Each program piece carries the smaller of two values: the bytes still to write, and four (MAX_CHUNK). A piece is never empty.
- R2: A piece is shortened when needed so that (address mod 256) plus the piece length is no more than 256. The bytes left over go in the next piece, which starts at the next page.
- R3: Before every program or erase command, the block sends a write-enable command: opcode 0x06, tx count 1, rx count 0.
- R4: A program command uses opcode 0x02, tx count equal to the piece length plus 4, and rx count 0. `cmd_addr` is the address of the piece. `cmd_wdata` holds the bytes in little-endian order: the first byte of the piece sits in bits 7:0, and byte lanes beyond the piece length are zero.
- R5: An erase command uses opcode 0xD8, tx count 4, rx count 0, and `cmd_addr` equal to the request address.
- R6: After each program or erase command, the block sends a status-read command (opcode 0x05, tx 1, rx 1). It repeats this while `eng_wip` is 1 when the engine reports completion. It moves on only when `eng_wip` is 0.
- R7: A write with address plus length greater than FLASH_BYTES is refused. An erase with address at or above FLASH_BYTES is also refused. For a refused request, `rsp_done` and `rsp_err` are both 1 in the cycle after acceptance, and no command is sent.
- R8: A write of length zero gives `rsp_done` with `rsp_err` equal to 0 in the cycle after acceptance, and sends no command. This holds even when the address lies outside the flash.
- R9: `rsp_done` is a single-cycle pulse. For a request that was carried out, it comes in the cycle after the engine reports the final clear status. `rsp_err` is never 1 without `rsp_done`.
- R10: `req_ready` is 1 only while the block is idle. While idle, `cmd_valid` is 0. While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields hold still.
- R11: `dat_ready` is 1 only while a piece is being filled. Exactly the request length in bytes is taken from the byte stream.
- R12: After reset, `req_ready` is 1, and `cmd_valid`, `dat_ready` and `rsp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request (it is idle) |
| req_erase | input | 1 | 1 for a sector erase, 0 for a write |
| req_addr | input | ADDR_W | Start address of the request |
| req_len | input | LEN_W | Write length in bytes; ignored for an erase |
| dat_valid | input | 1 | A write byte is offered |
| dat_ready | output | 1 | The block takes the offered byte |
| dat_byte | input | 8 | Write byte |
| rsp_done | output | 1 | Request finished (one-cycle pulse) |
| rsp_err | output | 1 | The finished request was refused |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | The engine accepts the command |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | 8*MAX_CHUNK | Program data, little-endian |
| cmd_tx | output | $clog2(MAX_CHUNK+5) | Bytes the engine sends |
| cmd_rx | output | $clog2(MAX_CHUNK+1) | Bytes the engine receives |
| eng_done | input | 1 | The engine finished the last accepted command (one cycle) |
| eng_wip | input | 1 | Bit 0 of the received status byte, valid with `eng_done` |

## Verification
Refused and zero-length requests must give `rsp_done` at the first sample after the accepting edge. The bench records the cycle number at acceptance and compares it with the cycle in which the response arrives. For a request that is carried out, the response is due one cycle after the engine model returns the last clear status. The bench marks that status and requires `rsp_done` at the very next sample. Each command is checked at the sample just before the handshake edge, against a queue of expected commands. The bench builds that queue from the page and piece rules. The engine model varies both its ready pattern and its completion delay, so every command stage is held for several different numbers of cycles.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FILL,
      S_WEN,
      S_WEN_W,
      S_OP,
      S_OP_W,
      S_POLL,
      S_POLL_W,
      S_RESP
   } seq_state_t;

   localparam logic [7:0] OPC_WREN   = 8'h06;
   localparam logic [7:0] OPC_PROG   = 8'h02;
   localparam logic [7:0] OPC_SERASE = 8'hD8;
   localparam logic [7:0] OPC_RDSR   = 8'h05;

endpackage

// File: rtl/seq_chunk_calc.sv
module seq_chunk_calc #(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 16,
   parameter int PAGE_BYTES = 256,
   parameter int MAX_CHUNK  = 4,
   parameter int CH_W       = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  remain,
   output logic [CH_W-1:0]   chunk
);
   localparam int PG_W = $clog2(PAGE_BYTES);

   logic [PG_W:0]   room;
   logic [LEN_W-1:0] cap;

   always_comb begin
      room = (PG_W+1)'(PAGE_BYTES) - {1'b0, addr[PG_W-1:0]};
      cap  = (remain < LEN_W'(MAX_CHUNK)) ? remain : LEN_W'(MAX_CHUNK);
      if (32'(room) < 32'(cap))
         chunk = CH_W'(room);
      else
         chunk = CH_W'(cap);
   end
endmodule

// File: rtl/seq_byte_packer.sv
module seq_byte_packer #(
   parameter int LANES = 4,
   parameter int CH_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               take,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word,
   output logic [CH_W-1:0]    fill
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fill <= '0;
      else if (clear)  fill <= '0;
      else if (take)   fill <= fill + CH_W'(1);
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           lane_q <= '0;
         else if (clear)                       lane_q <= '0;
         else if (take && fill == CH_W'(i))    lane_q <= din;
      end
      assign word[8*i +: 8] = lane_q;
   end
endmodule

// File: rtl/seq_range_chk.sv
module seq_range_chk #(
   parameter int              ADDR_W      = 24,
   parameter int              LEN_W       = 16,
   parameter longint unsigned FLASH_BYTES = 64'd1048576
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              erase,
   output logic              reject,
   output logic              empty
);
   logic [63:0] start_pos;
   logic [63:0] end_pos;

   always_comb begin
      start_pos = 64'(addr);
      end_pos   = start_pos + 64'(len);
      empty     = !erase && (len == '0);
      if (erase)
         reject = (start_pos >= FLASH_BYTES);
      else
         reject = (end_pos > FLASH_BYTES);
   end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
   import flash_seq_pkg::*;
#(
   parameter int              ADDR_W      = 24,
   parameter int              LEN_W       = 16,
   parameter int              PAGE_BYTES  = 256,
   parameter int              MAX_CHUNK   = 4,
   parameter longint unsigned FLASH_BYTES = 64'd1048576,
   parameter logic [7:0]      OP_WREN     = OPC_WREN,
   parameter logic [7:0]      OP_PROG     = OPC_PROG,
   parameter logic [7:0]      OP_SERASE   = OPC_SERASE,
   parameter logic [7:0]      OP_RDSR     = OPC_RDSR
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               req_valid,
   output logic                               req_ready,
   input  logic                               req_erase,
   input  logic [ADDR_W-1:0]                  req_addr,
   input  logic [LEN_W-1:0]                   req_len,
   input  logic                               dat_valid,
   output logic                               dat_ready,
   input  logic [7:0]                         dat_byte,
   output logic                               rsp_done,
   output logic                               rsp_err,
   output logic                               cmd_valid,
   input  logic                               cmd_ready,
   output logic [7:0]                         cmd_op,
   output logic [ADDR_W-1:0]                  cmd_addr,
   output logic [8*MAX_CHUNK-1:0]             cmd_wdata,
   output logic [$clog2(MAX_CHUNK+5)-1:0]     cmd_tx,
   output logic [$clog2(MAX_CHUNK+1)-1:0]     cmd_rx,
   input  logic                               eng_done,
   input  logic                               eng_wip
);
   localparam int CH_W = $clog2(MAX_CHUNK+1);
   localparam int TX_W = $clog2(MAX_CHUNK+5);
   localparam int DW   = 8*MAX_CHUNK;

   // elaboration-time parameter checks
   if ((PAGE_BYTES & (PAGE_BYTES-1)) != 0 || PAGE_BYTES < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (MAX_CHUNK < 1 || MAX_CHUNK > PAGE_BYTES) begin : g_bad_chunk
      $error("MAX_CHUNK out of range");
   end
   if (ADDR_W > 32 || LEN_W > 32 || LEN_W < CH_W) begin : g_bad_width
      $error("ADDR_W/LEN_W out of range");
   end
   if ($clog2(PAGE_BYTES) > ADDR_W) begin : g_bad_addr
      $error("page larger than address space");
   end

   seq_state_t        state;
   logic              is_erase;
   logic              err_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  remain;

   logic [CH_W-1:0]   chunk;
   logic [CH_W-1:0]   fill;
   logic [DW-1:0]     pk_word;
   logic              pk_clear;
   logic              dat_take;
   logic              reject;
   logic              empty;
   logic              cmd_fire;

   seq_chunk_calc #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
      .MAX_CHUNK(MAX_CHUNK), .CH_W(CH_W)
   ) u_chunk (
      .addr(cur_addr), .remain(remain), .chunk(chunk)
   );

   seq_byte_packer #(.LANES(MAX_CHUNK), .CH_W(CH_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clear(pk_clear), .take(dat_take),
      .din(dat_byte), .word(pk_word), .fill(fill)
   );

   seq_range_chk #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FLASH_BYTES(FLASH_BYTES)
   ) u_range (
      .addr(req_addr), .len(req_len), .erase(req_erase),
      .reject(reject), .empty(empty)
   );

   assign req_ready = (state == S_IDLE);
   assign dat_ready = (state == S_FILL) && (fill < chunk);
   assign dat_take  = dat_valid && dat_ready;
   assign pk_clear  = (state == S_IDLE) || (state == S_POLL_W);
   assign cmd_valid = (state == S_WEN) || (state == S_OP) || (state == S_POLL);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign rsp_done  = (state == S_RESP);
   assign rsp_err   = (state == S_RESP) && err_q;
   assign cmd_addr  = cur_addr;
   assign cmd_wdata = is_erase ? '0 : pk_word;

   always_comb begin
      cmd_op = '0;
      cmd_tx = '0;
      cmd_rx = '0;
      unique case (state)
         S_WEN: begin
            cmd_op = OP_WREN;
            cmd_tx = TX_W'(1);
         end
         S_OP: begin
            if (is_erase) begin
               cmd_op = OP_SERASE;
               cmd_tx = TX_W'(4);
            end else begin
               cmd_op = OP_PROG;
               cmd_tx = TX_W'(chunk) + TX_W'(4);
            end
         end
         S_POLL: begin
            cmd_op = OP_RDSR;
            cmd_tx = TX_W'(1);
            cmd_rx = CH_W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         is_erase <= 1'b0;
         err_q    <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (req_valid) begin
               is_erase <= req_erase;
               cur_addr <= req_addr;
               remain   <= req_len;
               if (empty) begin
                  err_q <= 1'b0;
                  state <= S_RESP;
               end else if (reject) begin
                  err_q <= 1'b1;
                  state <= S_RESP;
               end else begin
                  err_q <= 1'b0;
                  state <= req_erase ? S_WEN : S_FILL;
               end
            end
            S_FILL:   if (dat_take && (fill + CH_W'(1) == chunk)) state <= S_WEN;
            S_WEN:    if (cmd_fire) state <= S_WEN_W;
            S_WEN_W:  if (eng_done) state <= S_OP;
            S_OP:     if (cmd_fire) state <= S_OP_W;
            S_OP_W:   if (eng_done) state <= S_POLL;
            S_POLL:   if (cmd_fire) state <= S_POLL_W;
            S_POLL_W: if (eng_done) begin
               if (eng_wip)
                  state <= S_POLL;
               else if (is_erase || remain == LEN_W'(chunk))
                  state <= S_RESP;
               else begin
                  cur_addr <= cur_addr + ADDR_W'(chunk);
                  remain   <= remain - LEN_W'(chunk);
                  state    <= S_FILL;
               end
            end
            S_RESP:   state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
   parameter int         ADDR_W     = 24,
   parameter int         PAGE_BYTES = 256,
   parameter int         MAX_CHUNK  = 4,
   parameter logic [7:0] OP_WREN    = 8'h06,
   parameter logic [7:0] OP_PROG    = 8'h02,
   parameter logic [7:0] OP_SERASE  = 8'hD8,
   parameter logic [7:0] OP_RDSR    = 8'h05
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_ready,
   input logic                           dat_ready,
   input logic                           rsp_done,
   input logic                           rsp_err,
   input logic                           cmd_valid,
   input logic                           cmd_ready,
   input logic [7:0]                     cmd_op,
   input logic [ADDR_W-1:0]              cmd_addr,
   input logic [$clog2(MAX_CHUNK+5)-1:0] cmd_tx,
   input logic [$clog2(MAX_CHUNK+1)-1:0] cmd_rx
);
   localparam int PG_W = $clog2(PAGE_BYTES);

   logic [7:0] last_op;
   logic       fire;
   assign fire = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last_op <= '0;
      else if (fire) last_op <= cmd_op;
   end

   p_wen_before_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (cmd_op == OP_PROG || cmd_op == OP_SERASE)) |-> (last_op == OP_WREN));

   p_chunk_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_op == OP_PROG) |-> (int'(cmd_tx) >= 5 && int'(cmd_tx) <= MAX_CHUNK + 4));

   p_page_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_op == OP_PROG) |->
         (int'(cmd_addr[PG_W-1:0]) + int'(cmd_tx) - 4 <= PAGE_BYTES));

   p_poll_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cmd_op == OP_RDSR) |-> (int'(cmd_tx) == 1 && int'(cmd_rx) == 1));

   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_tx)));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!cmd_valid && !dat_ready));

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
endmodule

bind flash_pe_seq flash_pe_seq_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK(MAX_CHUNK),
   .OP_WREN(OP_WREN), .OP_PROG(OP_PROG), .OP_SERASE(OP_SERASE), .OP_RDSR(OP_RDSR)
) u_chk (.*);

// File: tb/sim_flash_pe_seq.sv
`timescale 1ns/1ps
module sim_flash_pe_seq;
   localparam longint FLASH = 64'd1048576;

   typedef struct {
      logic [7:0]  op;
      logic [23:0] a;
      logic [31:0] d;
      int          tx;
      int          rx;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_erase = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        dat_valid = 1'b0;
   logic        dat_ready;
   logic [7:0]  dat_byte = '0;
   logic        rsp_done;
   logic        rsp_err;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [7:0]  cmd_op;
   logic [23:0] cmd_addr;
   logic [31:0] cmd_wdata;
   logic [3:0]  cmd_tx;
   logic [2:0]  cmd_rx;
   logic        eng_done = 1'b0;
   logic        eng_wip = 1'b0;

   flash_pe_seq u0 (.*);

   always #4 clk = ~clk;

   int   n_checks = 0;
   int   n_fail = 0;
   int   cyc = 0;
   exp_t eq[$];
   logic [7:0] dq[$];
   int   busy_cfg = 0;
   int   busy_left = 0;
   int   timer = 0;
   logic [7:0] pend_op = '0;
   bit   last_clear = 0;
   bit   rsp_pending = 0;
   bit   rsp_exp_err = 0;
   bit   rsp_imm = 0;
   int   acc_cyc = 0;
   bit   ended = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   // engine model, byte source and per-clock comparison
   always @(negedge clk) if (rst_n) begin
      if (rsp_err && !rsp_done) chk(0, "R9", "error without done", 1, 0);
      if (rsp_done) begin
         if (!rsp_pending) chk(0, "R9", "unexpected done", 1, 0);
         else begin
            chk(rsp_err == rsp_exp_err, rsp_imm ? "R7 R8" : "R9", "error flag", rsp_err, rsp_exp_err);
            if (rsp_imm) chk(cyc == acc_cyc, "R7 R8", "done cycle", cyc, acc_cyc);
            else chk(last_clear, "R9", "done right after clear status", last_clear, 1);
            chk(eq.size() == 0, "R9", "commands outstanding", eq.size(), 0);
            chk(dq.size() == 0, "R11", "bytes not taken", dq.size(), 0);
            rsp_pending = 0;
         end
      end

      last_clear = 0;
      if (timer > 0) begin
         timer--;
         eng_done = (timer == 0);
         if (timer == 0 && pend_op == 8'h05) begin
            eng_wip    = (busy_left > 0);
            last_clear = (busy_left == 0);
            if (busy_left > 0) busy_left--;
         end else eng_wip = 1'b0;
      end else begin
         eng_done = 1'b0;
         eng_wip  = 1'b0;
      end

      dat_valid = (dq.size() > 0) && (cyc % 4 != 2);
      dat_byte  = (dq.size() > 0) ? dq[0] : 8'h00;
      if (dat_ready && dq.size() == 0) chk(0, "R11", "byte wanted beyond length", 1, 0);
      if (dat_valid && dat_ready) void'(dq.pop_front());

      cmd_ready = (cyc % 3 != 1);
      if (cmd_valid && cmd_ready) begin
         if (eq.size() == 0) chk(0, "R10", "command with none expected", cmd_op, 0);
         else begin
            exp_t e;
            string tg;
            e = eq.pop_front();
            tg = (e.op == 8'h06) ? "R3" : (e.op == 8'h02) ? "R1 R2 R4" :
                 (e.op == 8'hD8) ? "R5" : "R6";
            chk(cmd_op == e.op, tg, "opcode", cmd_op, e.op);
            chk(int'(cmd_tx) == e.tx, tg, "tx count", cmd_tx, e.tx);
            chk(int'(cmd_rx) == e.rx, tg, "rx count", cmd_rx, e.rx);
            if (e.op == 8'h02) begin
               chk(cmd_addr == e.a, tg, "piece address", cmd_addr, e.a);
               chk(cmd_wdata == e.d, tg, "piece data", cmd_wdata, e.d);
            end
            if (e.op == 8'hD8) chk(cmd_addr == e.a, tg, "sector address", cmd_addr, e.a);
         end
         pend_op = cmd_op;
         timer   = 1 + (cyc % 2);
         if (cmd_op == 8'h02 || cmd_op == 8'hD8) busy_left = busy_cfg;
      end
   end

   task automatic push_cmd(input logic [7:0] op, input logic [23:0] a,
                           input logic [31:0] d, input int tx, input int rx);
      exp_t e;
      e.op = op; e.a = a; e.d = d; e.tx = tx; e.rx = rx;
      eq.push_back(e);
   endtask

   task automatic push_polls(input int busy);
      for (int k = 0; k <= busy; k++) push_cmd(8'h05, '0, '0, 1, 1);
   endtask

   task automatic issue(input bit erase, input longint addr, input int len, input int busy);
      bit zero, bad;
      zero = !erase && (len == 0);
      bad  = !zero && (erase ? (addr >= FLASH) : (addr + len > FLASH));
      busy_cfg = busy;
      if (!zero && !bad) begin
         if (erase) begin
            push_cmd(8'h06, '0, '0, 1, 0);
            push_cmd(8'hD8, 24'(addr), '0, 4, 0);
            push_polls(busy);
         end else begin
            longint a = addr;
            int r = len;
            int idx = 0;
            while (r > 0) begin
               int c = (r < 4) ? r : 4;
               int room = 256 - int'(a % 256);
               logic [31:0] d = '0;
               if (room < c) c = room;
               for (int k = 0; k < c; k++) begin
                  logic [7:0] b = 8'(idx * 29 + int'(addr) + 7);
                  d[8*k +: 8] = b;
                  dq.push_back(b);
                  idx++;
               end
               push_cmd(8'h06, '0, '0, 1, 0);
               push_cmd(8'h02, 24'(a), d, c + 4, 0);
               push_polls(busy);
               a += c;
               r -= c;
            end
         end
      end
      @(negedge clk);
      req_erase = erase;
      req_addr  = 24'(addr);
      req_len   = 16'(len);
      req_valid = 1'b1;
      rsp_exp_err = bad;
      rsp_imm     = zero || bad;
      rsp_pending = 1;
      while (!req_ready) @(negedge clk);
      acc_cyc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
      while (rsp_pending) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "R9", "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
      chk(cmd_valid == 1'b0, "R12", "cmd_valid after reset", cmd_valid, 0);
      chk(dat_ready == 1'b0, "R12", "dat_ready after reset", dat_ready, 0);
      chk(rsp_done == 1'b0, "R12", "rsp_done after reset", rsp_done, 0);

      issue(0, 64'h100, 4, 1);      // R1 aligned full piece
      issue(0, 64'h1FE, 7, 2);      // R2 pieces 2,4,1
      issue(0, 64'h0FF, 3, 0);      // R2 pieces 1,2
      issue(1, 64'h10000, 0, 3);    // R5 R6 erase with busy polls
      issue(1, 64'h100000, 0, 0);   // R7 erase past end
      issue(0, 64'hFFFFE, 3, 0);    // R7 write past end
      issue(0, 64'hFFFFC, 4, 1);    // R7 boundary accepted
      issue(0, 64'hFFFFFF, 0, 0);   // R8 zero length out of range
      issue(0, 64'h2FA, 9, 0);      // R1 R2 pieces 4,2,3
      issue(1, 64'hFFFFF, 0, 1);    // R5 last address
      issue(0, 64'h40, 1, 2);       // R4 single byte, upper lanes zero
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R10", "idle after traffic", req_ready, 1);
      finish_up();
   end
endmodule